// File: doc/BRIEF.md
# Tri-State Bus Register Line

This block is a single storage word whose read port is a tri-state driver on a shared bus. An 8-bit word is written on a rising clock edge when the line is selected and its write enable is high. The word is placed on the bus only while the line is selected and its read enable is high. At all other times every bus bit is released to high impedance, so other agents can drive the same wires. The design needs no multiplexer to share the bus. It is the basic cell from which larger bus-based memories are tiled: an external decoder drives one line select per word, and all outputs share one bus.

The clear input acts on its falling edge. The reset pin is sampled on the clock. While it is high, the stored word is frozen and writes are refused. The word is cleared on the first clock edge at which the pin is seen low after having been high. The output tri-state stage is a separate, bit-sliced buffer module.

Top module: `bus_reg_line`

## Requirements
- R1: On a rising clock edge where `line_sel` and `wr_en` are both 1, `rst` is 0 and `rst` was also 0 at the previous edge, the stored word becomes `wr_data`.
- R2: On a rising clock edge where `line_sel` or `wr_en` is 0, and no clear occurs, the stored word is unchanged.
- R3: On the first rising edge at which `rst` is sampled 0 after being sampled 1 at the previous edge, the stored word becomes 8'h00. This clear wins over a write requested at the same edge.
- R4: While `rst` is sampled 1, the stored word keeps its value. It is neither cleared nor written, even with `line_sel` and `wr_en` high.
- R5: While `line_sel` and `rd_en` are both 1, `bus_io` carries the stored word. This is combinational, with no clock delay.
- R6: While `line_sel` or `rd_en` is 0, every bit of `bus_io` is high impedance. A value driven onto the bus by another agent is then read back unchanged.
- R7: When read and write are active together, `bus_io` shows the previously stored word until the clock edge. After the edge it shows the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and clear take effect on its rising edge |
| rst | input | 1 | Clear request, active high; the clear occurs at its sampled falling edge |
| line_sel | input | 1 | Selects this line for read or write |
| rd_en | input | 1 | Read enable; with `line_sel`, drives the bus |
| wr_en | input | 1 | Write enable; with `line_sel`, captures `wr_data` |
| wr_data | input | 8 | Word to be stored |
| bus_io | inout | 8 | Shared data bus; driven when read, high impedance otherwise |

## Verification
The hardest situation to bring about is the clear edge coinciding with a write request. A stored value is first written and then held through a reset pulse whose high phase also carries a write attempt. Reset is then dropped in the same cycle that select and write enable are high, so the clear must override the write. The released-bus state cannot be seen directly on a resolved wire. The bench therefore drives two complementary patterns of its own onto the bus and reads them back. Any stray drive from the line, which holds a nonzero word at that time, would corrupt at least one of the two patterns.

// File: rtl/bus_reg_line_pkg.sv
package bus_reg_line_pkg;

    localparam int unsigned WORD_W_DEF = 8;

    typedef struct packed {
        logic load;   // capture the input word
        logic clear;  // zero the stored word
        logic drive;  // enable the bus drivers
    } line_cmd_t;

    function automatic line_cmd_t decode_cmd(
        input logic sel,
        input logic rd,
        input logic wr,
        input logic rst_now,
        input logic rst_prev
    );
        line_cmd_t c;
        c.clear = rst_prev & ~rst_now;
        c.load  = sel & wr & ~rst_now & ~c.clear;
        c.drive = sel & rd;
        return c;
    endfunction

endpackage

// File: rtl/line_ctrl.sv
module line_ctrl
    import bus_reg_line_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel,
    input  logic      rd,
    input  logic      wr,
    output line_cmd_t cmd
);

    logic rst_prev;

    always_ff @(posedge clk) begin
        rst_prev <= rst;
    end

    always_comb begin
        cmd = decode_cmd(sel, rd, wr, rst, rst_prev);
    end

endmodule

// File: rtl/line_store.sv
module line_store
    import bus_reg_line_pkg::*;
#(
    parameter int unsigned W = WORD_W_DEF
) (
    input  logic         clk,
    input  line_cmd_t    cmd,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (cmd.clear) begin
            q <= '0;
        end else if (cmd.load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/tri_buf.sv
module tri_buf #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic         oe,
    output wire  [W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = oe ? a[i] : 1'bz;
    end

endmodule

// File: rtl/bus_reg_line.sv
module bus_reg_line
    import bus_reg_line_pkg::*;
#(
    parameter int unsigned W = WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line_sel,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    inout  wire  [W-1:0] bus_io
);

    line_cmd_t    cmd;
    logic [W-1:0] word_q;

    line_ctrl u_ctrl (
        .clk (clk),
        .rst (rst),
        .sel (line_sel),
        .rd  (rd_en),
        .wr  (wr_en),
        .cmd (cmd)
    );

    line_store #(.W(W)) u_store (
        .clk (clk),
        .cmd (cmd),
        .d   (wr_data),
        .q   (word_q)
    );

    tri_buf #(.W(W)) u_drv (
        .a  (word_q),
        .oe (cmd.drive),
        .y  (bus_io)
    );

endmodule

// File: rtl/bus_reg_line_chk.sv
module bus_reg_line_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         line_sel,
    input logic         rd_en,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] bus_io,
    input logic [W-1:0] word_q
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (armed && line_sel && wr_en && !$fell(rst)) |=> (word_q == $past(wr_data))); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (armed && !(line_sel && wr_en) && !$fell(rst)) |=> $stable(word_q)); // R2

    AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (armed && $fell(rst)) |=> (word_q == '0)); // R3

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (armed && line_sel && rd_en) |-> (bus_io == word_q)); // R5

endmodule

bind bus_reg_line bus_reg_line_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .line_sel (line_sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .bus_io   (bus_io),
    .word_q   (word_q)
);

// File: tb/bus_reg_line_test.sv
`timescale 1ns/1ps
module bus_reg_line_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_sel = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_val = 8'h00;
    wire  [7:0] bus_w;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign bus_w = tb_oe ? tb_val : 8'bz;

    always #10 clk = ~clk;   // 50 MHz

    bus_reg_line uut (
        .clk      (clk),
        .rst      (rst),
        .line_sel (line_sel),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .bus_io   (bus_w)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock edge; returns at the following falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        line_sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic write_word(input logic [7:0] v);
        line_sel = 1'b1; wr_en = 1'b1; rd_en = 1'b0; wr_data = v;
        tick();
        idle();
    endtask

    task automatic read_expect(input string req, input logic [7:0] exp);
        tb_oe = 1'b0;
        line_sel = 1'b1; rd_en = 1'b1; wr_en = 1'b0;
        #2;
        check(req, bus_w, exp);
        idle();
        #1;
    endtask

    task automatic float_expect(input string req);
        tb_oe = 1'b1;
        tb_val = 8'hA5; #2;
        check(req, bus_w, 8'hA5);
        tb_val = 8'h5A; #2;
        check(req, bus_w, 8'h5A);
        tb_oe = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1; idle();
        tick(); tick();
        rst = 1'b0;
        tick();
        read_expect("R3 clear after reset release", 8'h00);
    endtask

    task automatic t_write_read();
        write_word(8'h3C);
        read_expect("R1 write 3C", 8'h3C);
        write_word(8'hC3);
        read_expect("R5 read C3", 8'hC3);
    endtask

    task automatic t_ignored_writes();
        line_sel = 1'b0; wr_en = 1'b1; wr_data = 8'hFF;
        tick(); idle();
        read_expect("R2 write with line_sel=0", 8'hC3);
        line_sel = 1'b1; wr_en = 1'b0; wr_data = 8'h0F;
        tick(); idle();
        read_expect("R2 write with wr_en=0", 8'hC3);
    endtask

    task automatic t_float();
        line_sel = 1'b0; rd_en = 1'b1; wr_en = 1'b0;
        float_expect("R6 float line_sel=0");
        line_sel = 1'b1; rd_en = 1'b0;
        float_expect("R6 float rd_en=0");
        line_sel = 1'b0; rd_en = 1'b0;
        float_expect("R6 float both low");
        idle();
    endtask

    task automatic t_read_during_write();
        tb_oe = 1'b0;
        line_sel = 1'b1; rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h96;
        #2;
        check("R7 old word before edge", bus_w, 8'hC3);
        tick();
        check("R7 new word after edge", bus_w, 8'h96);
        idle();
    endtask

    task automatic t_reset_hold_and_priority();
        rst = 1'b1;
        line_sel = 1'b1; wr_en = 1'b1; wr_data = 8'h11;
        tick(); tick();
        idle();
        read_expect("R4 hold while reset high", 8'h96);
        rst = 1'b0;
        line_sel = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
        tick();
        idle();
        read_expect("R3 clear beats write", 8'h00);
        write_word(8'h77);
        read_expect("R1 write after clear", 8'h77);
        line_sel = 1'b1; rd_en = 1'b0;
        float_expect("R6 float with 77 stored");
        idle();
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_write_read();
        t_ignored_writes();
        t_float();
        t_read_during_write();
        t_reset_hold_and_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule